// File: doc/BRIEF.md
# Matrix Operand Routing Switch

This block sits between a per-subchannel data memory and a vector arithmetic core. Every memory word carries the complete working set of one OFDM subchannel: several complex NRX-by-NRX matrix variables laid side by side. On the read side, a gather switch pulls one NRX-lane complex vector out of that word. It first selects the matrix variable and then, per lane, the element within it. The vector can be a row, a column, the main diagonal, or any per-lane mix of element positions.

On the write side, a scatter switch uses the same geometry in reverse. It drops the core's NRX result lanes into chosen positions of the subchannel word that is being written back. A per-lane write mask decides which lanes land. Every position that no enabled lane targets keeps the old word contents, so the memory can do a read-modify-write in one pass.

Both directions are steered directly by instruction fields and add no processing cycles. A parameter chooses between a purely combinational path and one output register stage.

Top module: `operand_route_switch`

## Requirements
- R1: With shape code 2'b00 (row), lane k of `vec_o` carries element (line, k) of the selected matrix variable. Element (r, c) of variable v sits at element index v*NRX*NRX + r*NRX + c of the word. Each element is 2*DW bits wide, with the real part in the upper half and the imaginary part in the lower half. Lane k occupies bits [k*2*DW +: 2*DW].
- R2: With shape code 2'b01 (column), lane k carries element (k, line) of the selected variable.
- R3: With shape code 2'b10 (diagonal), lane k carries element (k, k) of the selected variable, and the line index has no effect.
- R4: With shape code 2'b11 (mixed), lane k carries the element whose in-matrix index r*NRX + c is given by bits [k*4 +: 4] of the select field. Lanes may repeat an element.
- R5: On the write side, lane k of `wr_res_i` is written to the position that the write shape, line and select fields map it to, using the same mapping as R1 to R4. This happens only when `wr_mask_i[k]` is set.
- R6: Every element position that no enabled lane targets equals the matching element of `wr_old_i`. This covers all other matrix variables, and the whole word when the mask is zero.
- R7: In mixed write mode, when several enabled lanes target the same position, the highest-numbered of those lanes wins.
- R8: With OUT_REG=1, both outputs reflect the inputs sampled at the preceding rising clock edge, so a change of inputs between edges does not reach the outputs. An asserted `rst_ni` clears both outputs to zero at once.
- R9: The read and write paths are independent: write controls do not alter `vec_o`, and read controls do not alter `wr_word_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output stage |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rd_word_i | input | NVAR*NRX*NRX*2*DW | Subchannel word read from memory |
| rd_var_i | input | log2(NVAR) | Matrix variable to read |
| rd_shape_i | input | 2 | Read shape: 00 row, 01 column, 10 diagonal, 11 mixed |
| rd_line_i | input | log2(NRX) | Row or column index for the read |
| rd_sel_i | input | NRX*log2(NRX*NRX) | Per-lane element index for mixed reads |
| vec_o | output | NRX*2*DW | Gathered operand vector |
| wr_old_i | input | NVAR*NRX*NRX*2*DW | Current memory contents of the target word |
| wr_var_i | input | log2(NVAR) | Matrix variable to write |
| wr_shape_i | input | 2 | Write shape, same codes as the read shape |
| wr_line_i | input | log2(NRX) | Row or column index for the write |
| wr_sel_i | input | NRX*log2(NRX*NRX) | Per-lane element index for mixed writes |
| wr_mask_i | input | NRX | Per-lane write enable |
| wr_res_i | input | NRX*2*DW | Result lanes from the core |
| wr_word_o | output | NVAR*NRX*NRX*2*DW | Merged word to write back |

## Verification
A wrong lane-position decode shows up as a misplaced or duplicated element in `vec_o`, or as a foreign value written into `wr_word_o`. This is visible in the very cycle after the controls are applied, because the only state is the optional output register. Filling every element of the word with a unique value makes any misrouting visible at the ports. This lets a sweep over every variable, shape, line and mask value pin the fault to one position. A write-merge fault, such as wrong masking or a wrong collision winner, corrupts either the target element or an unrelated variable, and comparing the whole word against the old contents catches both.

// File: rtl/ors_pkg.sv
package ors_pkg;
  typedef enum logic [1:0] {
    SHP_ROW  = 2'b00,
    SHP_COL  = 2'b01,
    SHP_DIAG = 2'b10,
    SHP_MIX  = 2'b11
  } shape_e;
endpackage

// File: rtl/ors_lane_map.sv
module ors_lane_map
  import ors_pkg::*;
#(
  parameter int NRX = 4,
  parameter int LW  = 2,
  parameter int EIW = 4
) (
  input  shape_e               shape_i,
  input  logic [LW-1:0]        line_i,
  input  logic [NRX*EIW-1:0]   sel_i,
  output logic [NRX*EIW-1:0]   pos_o
);
  for (genvar k = 0; k < NRX; k++) begin : g_lane
    logic [EIW-1:0] p;
    always_comb begin
      case (shape_i)
        SHP_ROW:  p = EIW'(line_i) * EIW'(NRX) + EIW'(k);
        SHP_COL:  p = EIW'(k * NRX) + EIW'(line_i);
        SHP_DIAG: p = EIW'(k * (NRX + 1));
        default:  p = sel_i[k*EIW +: EIW];
      endcase
    end
    assign pos_o[k*EIW +: EIW] = p;
  end
endmodule

// File: rtl/ors_gather.sv
module ors_gather #(
  parameter int NRX    = 4,
  parameter int NVAR   = 4,
  parameter int ELEM_W = 32,
  parameter int VW     = 2,
  parameter int EIW    = 4,
  localparam int MAT_W  = NRX * NRX * ELEM_W,
  localparam int WORD_W = NVAR * MAT_W
) (
  input  logic [WORD_W-1:0]     word_i,
  input  logic [VW-1:0]         var_i,
  input  logic [NRX*EIW-1:0]    pos_i,
  output logic [NRX*ELEM_W-1:0] vec_o
);
  // level 1: matrix variable
  logic [MAT_W-1:0] mat;
  assign mat = word_i[var_i*MAT_W +: MAT_W];

  // level 2: element per lane
  for (genvar k = 0; k < NRX; k++) begin : g_lane
    assign vec_o[k*ELEM_W +: ELEM_W] = mat[pos_i[k*EIW +: EIW]*ELEM_W +: ELEM_W];
  end
endmodule

// File: rtl/ors_scatter.sv
module ors_scatter #(
  parameter int NRX    = 4,
  parameter int NVAR   = 4,
  parameter int ELEM_W = 32,
  parameter int VW     = 2,
  parameter int EIW    = 4,
  localparam int MAT_W  = NRX * NRX * ELEM_W,
  localparam int WORD_W = NVAR * MAT_W
) (
  input  logic [WORD_W-1:0]     old_i,
  input  logic [VW-1:0]         var_i,
  input  logic [NRX*EIW-1:0]    pos_i,
  input  logic [NRX-1:0]        mask_i,
  input  logic [NRX*ELEM_W-1:0] res_i,
  output logic [WORD_W-1:0]     word_o
);
  logic [MAT_W-1:0] mat_old, mat_new;
  assign mat_old = old_i[var_i*MAT_W +: MAT_W];

  // ascending lane order: highest enabled lane wins a collision
  always_comb begin
    mat_new = mat_old;
    for (int k = 0; k < NRX; k++) begin
      if (mask_i[k]) mat_new[pos_i[k*EIW +: EIW]*ELEM_W +: ELEM_W] = res_i[k*ELEM_W +: ELEM_W];
    end
  end

  for (genvar v = 0; v < NVAR; v++) begin : g_var
    assign word_o[v*MAT_W +: MAT_W] = (var_i == VW'(v)) ? mat_new : old_i[v*MAT_W +: MAT_W];
  end
endmodule

// File: rtl/ors_out_stage.sv
module ors_out_stage #(
  parameter int W  = 1,
  parameter bit EN = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (EN) begin : g_reg
    logic [W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else         q <= d_i;
    end
    assign q_o = q;
  end else begin : g_wire
    assign q_o = d_i;
  end
endmodule

// File: rtl/operand_route_switch.sv
module operand_route_switch
  import ors_pkg::*;
#(
  parameter int NRX     = 4,
  parameter int NVAR    = 4,
  parameter int DW      = 16,
  parameter bit OUT_REG = 1'b1,
  localparam int ELEM_W = 2 * DW,
  localparam int WORD_W = NVAR * NRX * NRX * ELEM_W,
  localparam int VW     = $clog2(NVAR),
  localparam int LW     = $clog2(NRX),
  localparam int EIW    = $clog2(NRX * NRX)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [WORD_W-1:0]     rd_word_i,
  input  logic [VW-1:0]         rd_var_i,
  input  logic [1:0]            rd_shape_i,
  input  logic [LW-1:0]         rd_line_i,
  input  logic [NRX*EIW-1:0]    rd_sel_i,
  output logic [NRX*ELEM_W-1:0] vec_o,
  input  logic [WORD_W-1:0]     wr_old_i,
  input  logic [VW-1:0]         wr_var_i,
  input  logic [1:0]            wr_shape_i,
  input  logic [LW-1:0]         wr_line_i,
  input  logic [NRX*EIW-1:0]    wr_sel_i,
  input  logic [NRX-1:0]        wr_mask_i,
  input  logic [NRX*ELEM_W-1:0] wr_res_i,
  output logic [WORD_W-1:0]     wr_word_o
);
  logic [NRX*EIW-1:0]    rd_pos, wr_pos;
  logic [NRX*ELEM_W-1:0] vec_d;
  logic [WORD_W-1:0]     word_d;

  ors_lane_map #(.NRX(NRX), .LW(LW), .EIW(EIW)) u_rd_map (
    .shape_i(shape_e'(rd_shape_i)), .line_i(rd_line_i), .sel_i(rd_sel_i), .pos_o(rd_pos)
  );

  ors_lane_map #(.NRX(NRX), .LW(LW), .EIW(EIW)) u_wr_map (
    .shape_i(shape_e'(wr_shape_i)), .line_i(wr_line_i), .sel_i(wr_sel_i), .pos_o(wr_pos)
  );

  ors_gather #(.NRX(NRX), .NVAR(NVAR), .ELEM_W(ELEM_W), .VW(VW), .EIW(EIW)) u_gather (
    .word_i(rd_word_i), .var_i(rd_var_i), .pos_i(rd_pos), .vec_o(vec_d)
  );

  ors_scatter #(.NRX(NRX), .NVAR(NVAR), .ELEM_W(ELEM_W), .VW(VW), .EIW(EIW)) u_scatter (
    .old_i(wr_old_i), .var_i(wr_var_i), .pos_i(wr_pos), .mask_i(wr_mask_i),
    .res_i(wr_res_i), .word_o(word_d)
  );

  ors_out_stage #(.W(NRX*ELEM_W), .EN(OUT_REG)) u_vec_stage (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(vec_d), .q_o(vec_o)
  );

  ors_out_stage #(.W(WORD_W), .EN(OUT_REG)) u_word_stage (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(word_d), .q_o(wr_word_o)
  );
endmodule

// File: rtl/ors_checker.sv
module ors_checker #(
  parameter int NRX     = 4,
  parameter int NVAR    = 4,
  parameter int DW      = 16,
  parameter bit OUT_REG = 1'b1,
  localparam int ELEM_W = 2 * DW,
  localparam int MAT_W  = NRX * NRX * ELEM_W,
  localparam int WORD_W = NVAR * MAT_W,
  localparam int VW     = $clog2(NVAR),
  localparam int LW     = $clog2(NRX)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [WORD_W-1:0]     rd_word_i,
  input logic [VW-1:0]         rd_var_i,
  input logic [1:0]            rd_shape_i,
  input logic [LW-1:0]         rd_line_i,
  input logic [NRX*ELEM_W-1:0] vec_o,
  input logic [WORD_W-1:0]     wr_old_i,
  input logic [VW-1:0]         wr_var_i,
  input logic [NRX-1:0]        wr_mask_i,
  input logic [WORD_W-1:0]     wr_word_o
);
  logic              primed;
  logic [WORD_W-1:0] rd_word_c, old_c;
  logic [VW-1:0]     rd_var_c, wr_var_c;
  logic [1:0]        rd_shape_c;
  logic [LW-1:0]     rd_line_c;
  logic [NRX-1:0]    mask_c;

  if (OUT_REG) begin : g_dly
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        primed <= 1'b0; rd_word_c <= '0; old_c <= '0; rd_var_c <= '0;
        wr_var_c <= '0; rd_shape_c <= '0; rd_line_c <= '0; mask_c <= '0;
      end else begin
        primed <= 1'b1; rd_word_c <= rd_word_i; old_c <= wr_old_i; rd_var_c <= rd_var_i;
        wr_var_c <= wr_var_i; rd_shape_c <= rd_shape_i; rd_line_c <= rd_line_i; mask_c <= wr_mask_i;
      end
    end
  end else begin : g_now
    assign primed = 1'b1;     assign rd_word_c = rd_word_i; assign old_c = wr_old_i;
    assign rd_var_c = rd_var_i; assign wr_var_c = wr_var_i; assign rd_shape_c = rd_shape_i;
    assign rd_line_c = rd_line_i; assign mask_c = wr_mask_i;
  end

  logic [MAT_W-1:0] rd_mat;
  assign rd_mat = rd_word_c[int'(rd_var_c)*MAT_W +: MAT_W];

  p_row_last_lane_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && rd_shape_c == 2'b00 |->
      vec_o[(NRX-1)*ELEM_W +: ELEM_W] == rd_mat[(int'(rd_line_c)*NRX + NRX-1)*ELEM_W +: ELEM_W]);

  p_col_first_lane_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && rd_shape_c == 2'b01 |->
      vec_o[0 +: ELEM_W] == rd_mat[int'(rd_line_c)*ELEM_W +: ELEM_W]);

  p_diag_last_lane_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && rd_shape_c == 2'b10 |->
      vec_o[(NRX-1)*ELEM_W +: ELEM_W] == rd_mat[MAT_W-ELEM_W +: ELEM_W]);

  p_mask_zero_keeps_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && mask_c == '0 |-> wr_word_o == old_c);

  for (genvar v = 0; v < NVAR; v++) begin : g_keep
    p_other_var_kept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      primed && wr_var_c != VW'(v) |->
        wr_word_o[v*MAT_W +: MAT_W] == old_c[v*MAT_W +: MAT_W]);
  end
endmodule

bind operand_route_switch ors_checker #(
  .NRX(NRX), .NVAR(NVAR), .DW(DW), .OUT_REG(OUT_REG)
) u_ors_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_word_i(rd_word_i), .rd_var_i(rd_var_i),
  .rd_shape_i(rd_shape_i), .rd_line_i(rd_line_i), .vec_o(vec_o), .wr_old_i(wr_old_i),
  .wr_var_i(wr_var_i), .wr_mask_i(wr_mask_i), .wr_word_o(wr_word_o)
);

// File: tb/operand_route_switch_bench.sv
module operand_route_switch_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NRX = 4;
  localparam int NVAR = 4;
  localparam int DW = 16;
  localparam int EW = 2 * DW;
  localparam int NE = NRX * NRX;
  localparam int WORD_W = NVAR * NE * EW;
  localparam int VEC_W = NRX * EW;
  localparam int EIW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [WORD_W-1:0] rd_word, wr_old, wr_word;
  logic [1:0] rd_var, rd_shape, rd_line, wr_var, wr_shape, wr_line;
  logic [NRX*EIW-1:0] rd_sel, wr_sel;
  logic [NRX-1:0] wr_mask;
  logic [VEC_W-1:0] wr_res, vec;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  operand_route_switch #(.NRX(NRX), .NVAR(NVAR), .DW(DW), .OUT_REG(1'b1)) u_operand_route_switch (
    .clk_i(clk), .rst_ni(rst_n),
    .rd_word_i(rd_word), .rd_var_i(rd_var), .rd_shape_i(rd_shape), .rd_line_i(rd_line),
    .rd_sel_i(rd_sel), .vec_o(vec),
    .wr_old_i(wr_old), .wr_var_i(wr_var), .wr_shape_i(wr_shape), .wr_line_i(wr_line),
    .wr_sel_i(wr_sel), .wr_mask_i(wr_mask), .wr_res_i(wr_res), .wr_word_o(wr_word)
  );

  function automatic logic [WORD_W-1:0] mk_word(int seed);
    logic [WORD_W-1:0] w;
    for (int e = 0; e < NVAR*NE; e++) w[e*EW +: EW] = {8'(e), 8'(seed), 16'(e*37 + seed*101)};
    return w;
  endfunction

  function automatic int pos_of(int shp, int line, logic [NRX*EIW-1:0] sel, int k);
    case (shp)
      0: return line*NRX + k;
      1: return k*NRX + line;
      2: return k*NRX + k;
      default: return int'(sel[k*EIW +: EIW]);
    endcase
  endfunction

  function automatic logic [VEC_W-1:0] exp_read(logic [WORD_W-1:0] w, int v, int shp, int line,
                                                 logic [NRX*EIW-1:0] sel);
    logic [VEC_W-1:0] r;
    for (int k = 0; k < NRX; k++) r[k*EW +: EW] = w[(v*NE + pos_of(shp, line, sel, k))*EW +: EW];
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] exp_write(logic [WORD_W-1:0] old, int v, int shp, int line,
      logic [NRX*EIW-1:0] sel, logic [NRX-1:0] mask, logic [VEC_W-1:0] res);
    logic [WORD_W-1:0] r;
    r = old;
    for (int k = 0; k < NRX; k++)
      if (mask[k]) r[(v*NE + pos_of(shp, line, sel, k))*EW +: EW] = res[k*EW +: EW];
    return r;
  endfunction

  task automatic chk_vec(string tag, logic [VEC_W-1:0] exp);
    checks++;
    if (vec !== exp) begin
      failures++;
      $display("FAIL %s vec_o actual=%h expected=%h", tag, vec, exp);
    end
  endtask

  task automatic chk_word(string tag, logic [WORD_W-1:0] exp);
    checks++;
    if (wr_word !== exp) begin
      failures++;
      $display("FAIL %s wr_word_o actual=%h expected=%h", tag, wr_word, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] lcg;
    logic [WORD_W-1:0] old_keep;
    rd_word = '0; rd_var = '0; rd_shape = '0; rd_line = '0; rd_sel = '0;
    wr_old = '0; wr_var = '0; wr_shape = '0; wr_line = '0; wr_sel = '0; wr_mask = '0; wr_res = '0;
    repeat (3) @(negedge clk);
    chk_vec("R8 reset", '0);
    chk_word("R8 reset", '0);
    rst_n = 1'b1;

    // R1/R2/R3 sweep, write mask zero (R6)
    for (int seed = 1; seed <= 2; seed++) begin
      for (int v = 0; v < NVAR; v++)
        for (int shp = 0; shp < 3; shp++)
          for (int line = 0; line < NRX; line++) begin
            rd_word = mk_word(seed); rd_var = 2'(v); rd_shape = 2'(shp); rd_line = 2'(line);
            wr_old = mk_word(seed + 7); wr_var = 2'(line); wr_mask = '0;
            step();
            case (shp)
              0: chk_vec("R1 row", exp_read(mk_word(seed), v, 0, line, '0));
              1: chk_vec("R2 column", exp_read(mk_word(seed), v, 1, line, '0));
              default: chk_vec("R3 diagonal", exp_read(mk_word(seed), v, 2, 0, '0));
            endcase
            chk_word("R6 mask zero", mk_word(seed + 7));
          end
    end

    // R4 mixed reads
    lcg = 32'h1234_5678;
    rd_shape = 2'b11;
    for (int n = 0; n < 64; n++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      rd_word = mk_word(n); rd_var = lcg[31:30]; rd_sel = lcg[23:8];
      step();
      chk_vec("R4 mixed", exp_read(mk_word(n), int'(lcg[31:30]), 3, 0, lcg[23:8]));
    end

    // R5/R6 write sweep with concurrent read (R9)
    rd_shape = 2'b10; rd_word = mk_word(9);
    for (int v = 0; v < NVAR; v++)
      for (int shp = 0; shp < 3; shp++)
        for (int line = 0; line < NRX; line++)
          for (int m = 0; m < 16; m++) begin
            wr_old = mk_word(v + 20); wr_var = 2'(v); wr_shape = 2'(shp); wr_line = 2'(line);
            wr_mask = 4'(m);
            for (int k = 0; k < NRX; k++) wr_res[k*EW +: EW] = {8'hC0 + 8'(k), 8'(m), 16'(v*100 + line)};
            rd_var = 2'((v + 1) % NVAR); rd_line = 2'(m % NRX);
            step();
            chk_word("R5 write merge", exp_write(mk_word(v + 20), v, shp, line, '0, 4'(m), wr_res));
            chk_vec("R9 read independent", exp_read(mk_word(9), (v + 1) % NVAR, 2, 0, '0));
          end

    // R7 mixed write collisions
    wr_shape = 2'b11; wr_var = 2'd2; wr_old = mk_word(40);
    wr_sel = {4'd5, 4'd5, 4'd5, 4'd5};
    for (int k = 0; k < NRX; k++) wr_res[k*EW +: EW] = 32'hAB00_0000 + 32'(k);
    wr_mask = 4'b1111;
    step();
    chk_word("R7 collision lane3", exp_write(mk_word(40), 2, 3, 0, wr_sel, 4'b1000, wr_res));
    wr_mask = 4'b0011;
    step();
    chk_word("R7 collision lane1", exp_write(mk_word(40), 2, 3, 0, wr_sel, 4'b0010, wr_res));
    wr_sel = {4'd15, 4'd0, 4'd15, 4'd0}; wr_mask = 4'b0111;
    step();
    chk_word("R7 partial collision", exp_write(mk_word(40), 2, 3, 0, wr_sel, 4'b0110, wr_res));

    // R8 latency: input change between edges does not reach outputs
    old_keep = wr_word;
    rd_shape = 2'b00; rd_var = 2'd3; rd_line = 2'd1; rd_word = mk_word(55);
    wr_mask = 4'b0000; wr_old = mk_word(56);
    step();
    rd_line = 2'd2; wr_old = mk_word(57);
    #1;
    chk_vec("R8 hold between edges", exp_read(mk_word(55), 3, 0, 1, '0));
    chk_word("R8 hold between edges", mk_word(56));
    step();
    chk_vec("R8 next edge", exp_read(mk_word(55), 3, 0, 2, '0));
    chk_word("R8 next edge", mk_word(57));
    if (old_keep === wr_word) $display("note: unchanged word");

    // R8 asynchronous reset mid-run
    #2 rst_n = 1'b0;
    #1;
    chk_vec("R8 async reset", '0);
    chk_word("R8 async reset", '0);
    @(negedge clk);
    rst_n = 1'b1;
    step();
    chk_vec("R8 after reset", exp_read(mk_word(55), 3, 0, 2, '0));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule